// File: doc/BRIEF.md
# Disk-Interface PIO Register Access Sequencer

This block runs one programmed-I/O register access at a time on the host side of a parallel disk-drive interface. A local requester presents a start pulse together with the direction, the register block to use (command or control), a 3-bit register address, 16 bits of write data and a flag for 8-bit register mode. The sequencer then asserts the chosen chip select and the address and steps through four timed phases before it returns read data and a one-cycle completion pulse.

The phases are IDLE, ADDR_SETUP, STROBE_ACTIVE, RECOVERY and DONE. The transitions are: IDLE to ADDR_SETUP on a start pulse; ADDR_SETUP to STROBE_ACTIVE when the setup count has run out; STROBE_ACTIVE to RECOVERY once the minimum active count has run out and the synchronized ready line is high, or when the ready wait limit is reached (abort); RECOVERY to DONE when the recovery count has run out; DONE to IDLE unconditionally. The setup, active and recovery lengths and the ready wait limit are configuration inputs. A count of zero acts as one cycle. The device can stretch the strobe by holding its ready line low. The ready line passes through a two-flop synchronizer before the state machine looks at it. During writes the block drives the shared bus from the start of ADDR_SETUP until the end of RECOVERY. In 8-bit mode only the low byte lane is driven, and the high lane stays released.

Top module: `dsk_pio_seq`

## Requirements
- R1: After reset, and at any time busy is low, both chip selects (active low) and both strobes (active low) are high, and busy and done are low.
- R2: With req_ctl = 0 only dev_cs0_n goes low during the access. With req_ctl = 1 only dev_cs1_n goes low. dev_addr carries req_addr and stays stable while a strobe is low.
- R3: The chip select is low with both strobes high for max(cfg_setup,1) cycles before the strobe, and for max(cfg_recov,1) cycles after the strobe before done.
- R4: When the synchronized ready is high, the strobe stays low for exactly max(cfg_active,1) cycles, and never for fewer.
- R5: If dev_rdy is low when the strobe starts and rises during the c-th cycle of the strobe, the strobe lasts max(max(cfg_active,1), c+2) cycles, provided this does not exceed the ready wait limit.
- R6: If ready has not come back after cfg_tmo extra cycles beyond the minimum active count, the strobe ends after max(cfg_active,1)+cfg_tmo cycles and tmo_err is 1 with done. Otherwise tmo_err is 0 with done.
- R7: A write (req_write = 1) pulses only dev_wr_n, and the full 16-bit req_wdata is on dev_d while the strobe is low.
- R8: A read (req_write = 0) pulses only dev_rd_n. rdata takes the 16-bit value on dev_d in the last strobe cycle and holds it after done.
- R9: In 8-bit mode (req_byte = 1), a read returns {8'h00, dev_d[7:0]} and a write puts req_wdata[7:0] on dev_d[7:0].
- R10: busy is high from the cycle after an accepted start through the done cycle. done is a one-cycle pulse followed by busy low. A start pulse while busy is ignored.
- R11: dev_rd_n and dev_wr_n are never low together, and a strobe is low only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_go | input | 1 | Start pulse, accepted only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ctl | input | 1 | 1 = control block (cs1), 0 = command block (cs0) |
| req_byte | input | 1 | 8-bit register mode (low lane only) |
| req_addr | input | 3 | Register address |
| req_wdata | input | 16 | Write data |
| cfg_setup | input | CNT_W | Address setup cycles |
| cfg_active | input | CNT_W | Minimum strobe-active cycles |
| cfg_recov | input | CNT_W | Recovery cycles |
| cfg_tmo | input | TMO_W | Extra cycles allowed for ready |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Ready wait limit hit, valid with done |
| rdata | output | 16 | Read data |
| dev_cs0_n | output | 1 | Command-block chip select, active low |
| dev_cs1_n | output | 1 | Control-block chip select, active low |
| dev_addr | output | 3 | Device register address |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_d | inout | 16 | Bidirectional data bus |
| dev_rdy | input | 1 | Device ready (low stretches the strobe) |

## Verification
The bound checker checks on every cycle the properties that hold at any time. These are: one chip select at most, one strobe at most, a strobe only under a chip select, a stable address while the strobe is low, quiet pins while idle, a single-cycle done followed by idle, and a strobe never shorter than the minimum active count. The exact phase lengths can only be shown by the bench's scenarios, because they depend on when the device raises ready. Those scenarios also cover the timeout abort and its error flag, the read data captured on either lane width, the write data on the bus and the dropping of a start pulse given while busy.

// File: rtl/dsk_pio_pkg.sv
package dsk_pio_pkg;

    localparam int PIO_DW   = 16;
    localparam int PIO_AW   = 3;
    localparam int PIO_LANE = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_STROBE_ACTIVE,
        ST_RECOVERY,
        ST_DONE
    } pio_state_t;

    typedef struct packed {
        logic              is_write;
        logic              ctl_blk;
        logic              byte_mode;
        logic [PIO_AW-1:0] addr;
        logic [PIO_DW-1:0] wdata;
    } pio_req_t;

endpackage

// File: rtl/dsk_pio_sync.sv
module dsk_pio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dsk_pio_timer.sv
module dsk_pio_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_val == '0) ? '0 : load_val - W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dsk_pio_fsm.sv
module dsk_pio_fsm
    import dsk_pio_pkg::*;
#(
    parameter int TMO_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             tmr_expired,
    input  logic             rdy_s,
    input  logic [TMO_W-1:0] cfg_tmo,
    output pio_state_t       state_q,
    output pio_state_t       state_d,
    output logic             accept,
    output logic             busy,
    output logic             cs_en,
    output logic             strobe_on,
    output logic             drive_en,
    output logic             done,
    output logic             capture,
    output logic             abort
);
    logic [TMO_W-1:0] wait_q;
    logic             wait_full;

    assign wait_full = (wait_q == cfg_tmo);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:          if (go) state_d = ST_ADDR_SETUP;
            ST_ADDR_SETUP:    if (tmr_expired) state_d = ST_STROBE_ACTIVE;
            ST_STROBE_ACTIVE: if (tmr_expired && (rdy_s || wait_full)) state_d = ST_RECOVERY;
            ST_RECOVERY:      if (tmr_expired) state_d = ST_DONE;
            ST_DONE:          state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ready wait counter, runs only once the minimum active count is spent
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else if (state_q != ST_STROBE_ACTIVE) begin
            wait_q <= '0;
        end else if (tmr_expired && !rdy_s && !wait_full) begin
            wait_q <= wait_q + TMO_W'(1);
        end
    end

    // outputs decoded from the state register
    always_comb begin
        accept    = 1'b0;
        busy      = 1'b1;
        cs_en     = 1'b0;
        strobe_on = 1'b0;
        drive_en  = 1'b0;
        done      = 1'b0;
        capture   = 1'b0;
        abort     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = go;
            end
            ST_ADDR_SETUP: begin
                cs_en    = 1'b1;
                drive_en = 1'b1;
            end
            ST_STROBE_ACTIVE: begin
                cs_en     = 1'b1;
                drive_en  = 1'b1;
                strobe_on = 1'b1;
                capture   = (state_d == ST_RECOVERY);
                abort     = tmr_expired && !rdy_s && wait_full;
            end
            ST_RECOVERY: begin
                cs_en    = 1'b1;
                drive_en = 1'b1;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/dsk_pio_datapath.sv
module dsk_pio_datapath
    import dsk_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic              abort,
    input  pio_req_t          req,
    input  logic              cs_en,
    input  logic              strobe_on,
    input  logic              drive_en,
    input  logic [PIO_DW-1:0] d_in,
    output logic [PIO_DW-1:0] rdata,
    output logic              tmo_err,
    output logic              cs0_n,
    output logic              cs1_n,
    output logic [PIO_AW-1:0] addr,
    output logic              rd_n,
    output logic              wr_n,
    output logic [PIO_DW-1:0] d_out,
    output logic              oe_lo,
    output logic              oe_hi
);
    localparam int HI_W = PIO_DW - PIO_LANE;

    pio_req_t req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            tmo_err <= 1'b0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                req_q   <= req;
                tmo_err <= 1'b0;
            end
            if (abort) tmo_err <= 1'b1;
            if (capture && !req_q.is_write) begin
                rdata <= req_q.byte_mode ? {{HI_W{1'b0}}, d_in[PIO_LANE-1:0]} : d_in;
            end
        end
    end

    always_comb begin
        cs0_n = !(cs_en && !req_q.ctl_blk);
        cs1_n = !(cs_en &&  req_q.ctl_blk);
        addr  = cs_en ? req_q.addr : '0;
        rd_n  = !(strobe_on && !req_q.is_write);
        wr_n  = !(strobe_on &&  req_q.is_write);
        oe_lo = drive_en && req_q.is_write;
        oe_hi = drive_en && req_q.is_write && !req_q.byte_mode;
        d_out = req_q.byte_mode ? {{HI_W{1'b0}}, req_q.wdata[PIO_LANE-1:0]} : req_q.wdata;
    end
endmodule

// File: rtl/dsk_pio_seq.sv
module dsk_pio_seq
    import dsk_pio_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int TMO_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_go,
    input  logic              req_write,
    input  logic              req_ctl,
    input  logic              req_byte,
    input  logic [PIO_AW-1:0] req_addr,
    input  logic [PIO_DW-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_active,
    input  logic [CNT_W-1:0]  cfg_recov,
    input  logic [TMO_W-1:0]  cfg_tmo,
    output logic              busy,
    output logic              done,
    output logic              tmo_err,
    output logic [PIO_DW-1:0] rdata,
    output logic              dev_cs0_n,
    output logic              dev_cs1_n,
    output logic [PIO_AW-1:0] dev_addr,
    output logic              dev_rd_n,
    output logic              dev_wr_n,
    inout  wire  [PIO_DW-1:0] dev_d,
    input  logic              dev_rdy
);
    pio_state_t        state_q, state_d;
    logic              rdy_s, tmr_expired, tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              accept, cs_en, strobe_on, drive_en, capture, abort;
    logic              oe_lo, oe_hi;
    logic [PIO_DW-1:0] d_out;
    pio_req_t          req;

    assign req = '{is_write: req_write, ctl_blk: req_ctl, byte_mode: req_byte,
                   addr: req_addr, wdata: req_wdata};

    dsk_pio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(dev_rdy), .q(rdy_s)
    );

    // phase length chosen by the state being entered
    always_comb begin
        unique case (state_d)
            ST_ADDR_SETUP:    tmr_val = cfg_setup;
            ST_STROBE_ACTIVE: tmr_val = cfg_active;
            default:          tmr_val = cfg_recov;
        endcase
    end
    assign tmr_load = (state_d != state_q);

    dsk_pio_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_expired)
    );

    dsk_pio_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(req_go), .tmr_expired(tmr_expired),
        .rdy_s(rdy_s), .cfg_tmo(cfg_tmo), .state_q(state_q), .state_d(state_d),
        .accept(accept), .busy(busy), .cs_en(cs_en), .strobe_on(strobe_on),
        .drive_en(drive_en), .done(done), .capture(capture), .abort(abort)
    );

    dsk_pio_datapath u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .abort(abort), .req(req), .cs_en(cs_en), .strobe_on(strobe_on),
        .drive_en(drive_en), .d_in(dev_d), .rdata(rdata), .tmo_err(tmo_err),
        .cs0_n(dev_cs0_n), .cs1_n(dev_cs1_n), .addr(dev_addr),
        .rd_n(dev_rd_n), .wr_n(dev_wr_n), .d_out(d_out),
        .oe_lo(oe_lo), .oe_hi(oe_hi)
    );

    assign dev_d[PIO_DW-1:PIO_LANE] = oe_hi ? d_out[PIO_DW-1:PIO_LANE] : 'z;
    assign dev_d[PIO_LANE-1:0]      = oe_lo ? d_out[PIO_LANE-1:0] : 'z;
endmodule

// File: rtl/dsk_pio_chk.sv
module dsk_pio_chk #(
    parameter int CNT_W = 6,
    parameter int AW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dev_cs0_n,
    input logic             dev_cs1_n,
    input logic             dev_rd_n,
    input logic             dev_wr_n,
    input logic [AW-1:0]    dev_addr,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] cfg_active
);
    localparam int LEN_W = CNT_W + 12;

    logic             strobe, prev_strobe_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] min_len;

    assign strobe  = !dev_rd_n || !dev_wr_n;
    assign min_len = (cfg_active == '0) ? LEN_W'(1) : LEN_W'(cfg_active);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q         <= '0;
            prev_strobe_q <= 1'b0;
        end else begin
            prev_strobe_q <= strobe;
            len_q         <= strobe ? len_q + LEN_W'(1) : '0;
        end
    end

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_cs0_n && !dev_cs1_n)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && prev_strobe_q) |-> $stable(dev_addr)); // R2
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dev_rd_n && !dev_wr_n)); // R11
    AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> (!dev_cs0_n || !dev_cs1_n)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_rd_n && dev_wr_n && dev_cs0_n && dev_cs1_n)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10
    AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_strobe_q && !strobe) |-> (len_q >= min_len)); // R4
endmodule

bind dsk_pio_seq dsk_pio_chk #(.CNT_W(CNT_W), .AW(dsk_pio_pkg::PIO_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dev_cs0_n(dev_cs0_n), .dev_cs1_n(dev_cs1_n),
    .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n), .dev_addr(dev_addr),
    .busy(busy), .done(done), .cfg_active(cfg_active)
);

// File: tb/tb_dsk_pio_seq.sv
module tb_dsk_pio_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_go = 1'b0, req_write = 1'b0, req_ctl = 1'b0, req_byte = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [5:0]  cfg_setup = 6'd1, cfg_active = 6'd1, cfg_recov = 6'd1;
    logic [9:0]  cfg_tmo = 10'd8;
    logic        busy, done, tmo_err;
    logic [15:0] rdata;
    logic        dev_cs0_n, dev_cs1_n, dev_rd_n, dev_wr_n;
    logic [2:0]  dev_addr;
    wire  [15:0] dev_d;
    logic        dev_rdy = 1'b1;
    logic [15:0] dev_val = '0;
    int          hold = 0;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        bit          wr;
        bit          ctl;
        bit          byt;
        logic [2:0]  addr;
        logic [15:0] wexp;
        logic [15:0] rexp;
        int          su;
        int          len;
        int          rc;
        bit          err;
    } exp_t;
    exp_t sbq[$];

    always #5 clk = ~clk;

    dsk_pio_seq dut (
        .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_write(req_write),
        .req_ctl(req_ctl), .req_byte(req_byte), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_setup(cfg_setup), .cfg_active(cfg_active),
        .cfg_recov(cfg_recov), .cfg_tmo(cfg_tmo), .busy(busy), .done(done),
        .tmo_err(tmo_err), .rdata(rdata), .dev_cs0_n(dev_cs0_n),
        .dev_cs1_n(dev_cs1_n), .dev_addr(dev_addr), .dev_rd_n(dev_rd_n),
        .dev_wr_n(dev_wr_n), .dev_d(dev_d), .dev_rdy(dev_rdy)
    );

    // device model: drives read data, raises ready after `hold` strobe cycles
    assign dev_d = (!dev_rd_n && (!dev_cs0_n || !dev_cs1_n)) ? dev_val : 16'hzzzz;

    int dcnt = 0;
    bit raised = 1'b0;
    always @(negedge clk) begin
        if (!busy) raised = 1'b0;
        if (!dev_rd_n || !dev_wr_n) begin
            dcnt++;
            if (hold != 0 && dcnt == hold) raised = 1'b1;
        end else begin
            dcnt = 0;
        end
        dev_rdy = (hold == 0) || raised;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: measures the phases of each access and compares at done
    int su_c = 0, len_c = 0, rc_c = 0;
    bit seen = 0, saw_rd = 0, saw_wr = 0, cs0_s = 0, cs1_s = 0, wbad = 0;
    logic [2:0] addr_s = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!dev_rd_n || !dev_wr_n) begin
                len_c++;
                seen = 1;
                if (!dev_rd_n) saw_rd = 1;
                if (!dev_wr_n) saw_wr = 1;
                if (!dev_cs0_n) cs0_s = 1;
                if (!dev_cs1_n) cs1_s = 1;
                addr_s = dev_addr;
                if (!dev_wr_n && sbq.size() != 0) begin
                    if (sbq[0].byt ? (dev_d[7:0] !== sbq[0].wexp[7:0])
                                   : (dev_d !== sbq[0].wexp)) wbad = 1;
                end
            end else if (!dev_cs0_n || !dev_cs1_n) begin
                if (seen) rc_c++; else su_c++;
            end
            if (done) begin
                if (sbq.size() == 0) begin
                    chk(0, "R10 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(su_c == e.su, "R3 setup cycles", su_c, e.su);
                    chk(rc_c == e.rc, "R3 recovery cycles", rc_c, e.rc);
                    chk(len_c == e.len, "R4/R5/R6 strobe cycles", len_c, e.len);
                    chk(tmo_err == e.err, "R6 tmo_err", int'(tmo_err), int'(e.err));
                    chk(cs0_s == !e.ctl && cs1_s == e.ctl, "R2 chip select",
                        {cs1_s, cs0_s}, {e.ctl, !e.ctl});
                    chk(addr_s == e.addr, "R2 address", addr_s, e.addr);
                    if (e.wr) begin
                        chk(saw_wr && !saw_rd, "R7 write strobe", {saw_wr, saw_rd}, 2);
                        chk(!wbad, e.byt ? "R9 byte write lane" : "R7 write data", int'(wbad), 0);
                    end else begin
                        chk(saw_rd && !saw_wr, "R8 read strobe", {saw_wr, saw_rd}, 1);
                        if (!e.err)
                            chk(rdata == e.rexp, e.byt ? "R9 byte read" : "R8 read data",
                                rdata, e.rexp);
                    end
                end
                su_c = 0; len_c = 0; rc_c = 0;
                seen = 0; saw_rd = 0; saw_wr = 0; cs0_s = 0; cs1_s = 0; wbad = 0;
            end
        end
    end

    function automatic int atleast1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // driver: computes the expected result, pushes it, starts the access
    task automatic access(input bit wr, input bit ctl, input bit byt, input logic [2:0] a,
                          input logic [15:0] wd, input logic [15:0] dv,
                          input int s, input int act, input int r, input int t,
                          input int hd, input bit poke);
        exp_t e;
        int am;
        am = atleast1(act);
        e.wr = wr; e.ctl = ctl; e.byt = byt; e.addr = a;
        e.wexp = byt ? {8'h00, wd[7:0]} : wd;
        e.rexp = byt ? {8'h00, dv[7:0]} : dv;
        e.su = atleast1(s); e.rc = atleast1(r);
        e.err = 0;
        if (hd == 0 || hd + 2 <= am) e.len = am;
        else if (hd + 2 <= am + t)   e.len = hd + 2;
        else begin e.len = am + t; e.err = 1; end
        @(negedge clk);
        cfg_setup = 6'(s); cfg_active = 6'(act); cfg_recov = 6'(r); cfg_tmo = 10'(t);
        hold = hd; dev_val = dv;
        req_write = wr; req_ctl = ctl; req_byte = byt; req_addr = a; req_wdata = wd;
        @(negedge clk);
        sbq.push_back(e);
        req_go = 1'b1;
        @(negedge clk);
        req_go = 1'b0;
        chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
        if (poke) begin
            @(negedge clk);
            req_addr = 3'd7; req_write = ~wr; req_ctl = ~ctl;
            req_go = 1'b1;
            @(negedge clk);
            req_go = 1'b0;
        end
        do begin
            @(negedge clk);
            #1;
        end while (sbq.size() != 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 idle after done", {busy, done}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(dev_rd_n && dev_wr_n && dev_cs0_n && dev_cs1_n, "R1 pins in reset",
            {dev_rd_n, dev_wr_n, dev_cs0_n, dev_cs1_n}, 15);
        chk(!busy && !done, "R1 busy/done in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(dev_rd_n && dev_wr_n && dev_cs0_n && dev_cs1_n && !busy, "R1 idle after reset",
            {dev_rd_n, dev_wr_n, dev_cs0_n, dev_cs1_n, busy}, 30);

        // R8 full-width read, command block
        access(0, 0, 0, 3'd3, 16'h0000, 16'hC3A5, 2, 3, 2, 20, 0, 0);
        // R7 full-width write, control block
        access(1, 1, 0, 3'd6, 16'h5AF0, 16'h0000, 1, 4, 3, 20, 0, 0);
        // R9 byte read
        access(0, 0, 1, 3'd1, 16'h0000, 16'hBEEF, 3, 2, 1, 20, 0, 0);
        // R9 byte write
        access(1, 0, 1, 3'd2, 16'h12A5, 16'h0000, 2, 2, 2, 20, 0, 0);
        // R5 stretched read: ready rises in strobe cycle 5
        access(0, 1, 0, 3'd4, 16'h0000, 16'h7E81, 1, 2, 1, 20, 5, 0);
        // R5 ready back before the minimum runs out
        access(1, 0, 0, 3'd5, 16'h0F0F, 16'h0000, 1, 8, 1, 20, 3, 0);
        // R6 timeout: ready never returns
        access(0, 0, 0, 3'd0, 16'h0000, 16'h1111, 1, 3, 2, 4, 1000, 0);
        // R6 error clears on the next good access
        access(0, 0, 0, 3'd7, 16'h0000, 16'h2222, 1, 1, 1, 4, 0, 0);
        // R3/R4 zero counts act as one cycle
        access(1, 1, 0, 3'd3, 16'hA5C3, 16'h0000, 0, 0, 0, 0, 0, 0);
        // R10 a start pulse while busy is ignored
        access(0, 0, 0, 3'd2, 16'h0000, 16'h9876, 2, 6, 2, 10, 0, 1);
        repeat (3) @(negedge clk);
        chk(!busy && sbq.size() == 0, "R10 no second access", int'(busy), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule